// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block sits behind a single write-only command register. Software writes one word that names a command kind, a target processor and a vector. The block decodes that word and turns it into per-processor actions. It can post an interrupt, request a reset, halt the processor, or resume it. Targets whose number is at or above the configured processor count are dropped without any effect. A reset command whose vector is not the power-on reset code is also dropped, and it raises a sticky error flag.

Command words arrive over a valid/ready input. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The interrupt post leaves on a valid/ready output, and this is the block's only source of back-pressure. Once `post_valid` is high, it and its payload stay unchanged until `post_ready` is seen high at a clock edge. While a post is pending and not being accepted, `cmd_ready` is low, so no command is lost. Reset, halt and resume requests are plain one-cycle pulses, one bit per processor. The per-processor halted status is a plain level output.

Top module: `ipi_dispatch`

## Requirements
- R1: The command word is 18 bits wide and its fields sit at fixed positions: kind in bits 17:16, target processor in bits 12:8, vector in bits 5:0. Bits 15:13 and 7:6 have no effect on any output.
- R2: Kind 0 with a present target sets `post_valid` one cycle after acceptance, with `post_cpu` equal to the target and `post_vec` equal to the vector.
- R3: While `post_valid` is high and `post_ready` is low, `post_valid`, `post_cpu` and `post_vec` hold their values and `cmd_ready` is low. With `post_ready` high, `post_valid` drops in the next cycle unless a new post is loaded.
- R4: Kind 1 with vector equal to `POR_VEC` raises bit `cpu` of `rst_req` for exactly the cycle after acceptance and clears that processor's `halted` bit.
- R5: Kind 1 with any other vector to a present target produces no request and sets `err_sticky`. `err_sticky` stays set until the block is reset.
- R6: Kind 2 raises bit `cpu` of `halt_req` for one cycle and sets `halted[cpu]`. The bit stays set through later interrupt posts and repeated halts to that processor.
- R7: Kind 3 raises bit `cpu` of `resume_req` for one cycle and clears `halted[cpu]`.
- R8: A command whose target is at or above `NUM_CPUS` changes no output. It produces no post, no pulse, no status change and no error, even for a bad reset vector.
- R9: After reset `post_valid`, all request pulses, `halted` and `err_sticky` are zero and `cmd_ready` is high.
- R10: Each accepted command produces at most one output action. `rst_req`, `halt_req` and `resume_req` are each one-hot or zero, and a pulse appears only in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word is offered |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_word | input | 18 | Command word (kind, target, vector) |
| post_valid | output | 1 | Interrupt post pending |
| post_ready | input | 1 | Consumer accepts the post |
| post_cpu | output | 5 | Target processor of the post |
| post_vec | output | 6 | Interrupt vector of the post |
| rst_req | output | NUM_CPUS | One-cycle reset request per processor |
| halt_req | output | NUM_CPUS | One-cycle halt request per processor |
| resume_req | output | NUM_CPUS | One-cycle resume request per processor |
| halted | output | NUM_CPUS | Processor is halted |
| err_sticky | output | 1 | A reset command had a bad vector |

## Verification
The bench builds the block with `NUM_CPUS` set to 6 and keeps the default `POR_VEC` of 1. With 6 processors, target 5 is the last present one and target 6 is the first absent one, so both sides of the presence boundary are tested. Target 31 can also be written, which shows that an out-of-range target with a bad reset vector raises no error. The default reset code lets vectors 1 and 2 test the accept and reject paths of the reset command.

// File: rtl/ipi_dispatch_pkg.sv
package ipi_dispatch_pkg;

  localparam int CPU_W    = 5;
  localparam int VEC_W    = 6;
  localparam int KIND_W   = 2;
  localparam int KIND_LSB = 16;
  localparam int CPU_LSB  = 8;
  localparam int VEC_LSB  = 0;
  localparam int WORD_W   = KIND_LSB + KIND_W;

  typedef enum logic [KIND_W-1:0] {
    CK_POST   = 2'd0,
    CK_RESET  = 2'd1,
    CK_IDLE   = 2'd2,
    CK_RESUME = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic [CPU_W-1:0] cpu;
    logic [VEC_W-1:0] vec;
  } cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter logic [VEC_W-1:0] POR_VEC = 6'd1
) (
  input  logic [WORD_W-1:0]  word,
  output cmd_t               cmd,
  output logic               present,
  output logic               por_ok,
  output logic [NUM_CPUS-1:0] sel
);
  localparam logic [CPU_W:0] LIMIT = (CPU_W+1)'(NUM_CPUS);

  always_comb begin
    cmd.kind = cmd_kind_e'(word[KIND_LSB +: KIND_W]);
    cmd.cpu  = word[CPU_LSB +: CPU_W];
    cmd.vec  = word[VEC_LSB +: VEC_W];
  end

  assign present = ({1'b0, cmd.cpu} < LIMIT);
  assign por_ok  = (cmd.vec == POR_VEC);

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_sel
    assign sel[i] = (cmd.cpu == CPU_W'(i));
  end
endmodule

// File: rtl/ipi_post_buf.sv
module ipi_post_buf
  import ipi_dispatch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CPU_W-1:0] load_cpu,
  input  logic [VEC_W-1:0] load_vec,
  output logic             post_valid,
  input  logic             post_ready,
  output logic [CPU_W-1:0] post_cpu,
  output logic [VEC_W-1:0] post_vec,
  output logic             can_take
);
  assign can_take = !post_valid || post_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else if (load) begin
      post_valid <= 1'b1;
      post_cpu   <= load_cpu;
      post_vec   <= load_vec;
    end else if (post_ready) begin
      post_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic do_rst,
  input  logic do_halt,
  input  logic do_resume,
  output logic rst_p,
  output logic halt_p,
  output logic resume_p,
  output logic halted
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_p    <= 1'b0;
      halt_p   <= 1'b0;
      resume_p <= 1'b0;
      halted   <= 1'b0;
    end else begin
      rst_p    <= hit && do_rst;
      halt_p   <= hit && do_halt;
      resume_p <= hit && do_resume;
      if (hit && do_halt)
        halted <= 1'b1;
      else if (hit && (do_rst || do_resume))
        halted <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter logic [VEC_W-1:0] POR_VEC = 6'd1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [WORD_W-1:0]   cmd_word,
  output logic                post_valid,
  input  logic                post_ready,
  output logic [CPU_W-1:0]    post_cpu,
  output logic [VEC_W-1:0]    post_vec,
  output logic [NUM_CPUS-1:0] rst_req,
  output logic [NUM_CPUS-1:0] halt_req,
  output logic [NUM_CPUS-1:0] resume_req,
  output logic [NUM_CPUS-1:0] halted,
  output logic                err_sticky
);
  cmd_t                cmd;
  logic                present, por_ok, accept, act;
  logic                do_post, do_rst, do_halt, do_resume, bad_rst;
  logic [NUM_CPUS-1:0] sel;

  ipi_cmd_decode #(.NUM_CPUS(NUM_CPUS), .POR_VEC(POR_VEC)) u_dec (
    .word(cmd_word), .cmd(cmd), .present(present), .por_ok(por_ok), .sel(sel)
  );

  assign accept    = cmd_valid && cmd_ready;
  assign act       = accept && present;
  assign do_post   = act && (cmd.kind == CK_POST);
  assign do_rst    = act && (cmd.kind == CK_RESET) && por_ok;
  assign bad_rst   = act && (cmd.kind == CK_RESET) && !por_ok;
  assign do_halt   = act && (cmd.kind == CK_IDLE);
  assign do_resume = act && (cmd.kind == CK_RESUME);

  ipi_post_buf u_post (
    .clk(clk), .rst_n(rst_n), .load(do_post),
    .load_cpu(cmd.cpu), .load_vec(cmd.vec),
    .post_valid(post_valid), .post_ready(post_ready),
    .post_cpu(post_cpu), .post_vec(post_vec), .can_take(cmd_ready)
  );

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    ipi_cpu_slot u_slot (
      .clk(clk), .rst_n(rst_n), .hit(sel[i]),
      .do_rst(do_rst), .do_halt(do_halt), .do_resume(do_resume),
      .rst_p(rst_req[i]), .halt_p(halt_req[i]), .resume_p(resume_req[i]),
      .halted(halted[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_sticky <= 1'b0;
    else if (bad_rst) err_sticky <= 1'b1;
  end
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk
  import ipi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                post_valid,
  input logic                post_ready,
  input logic [CPU_W-1:0]    post_cpu,
  input logic [VEC_W-1:0]    post_vec,
  input logic [NUM_CPUS-1:0] rst_req,
  input logic [NUM_CPUS-1:0] halt_req,
  input logic [NUM_CPUS-1:0] resume_req,
  input logic [NUM_CPUS-1:0] halted,
  input logic                err_sticky
);
  localparam logic [CPU_W:0] LIMIT = (CPU_W+1)'(NUM_CPUS);

  assert_post_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !post_ready) |=> (post_valid && $stable(post_cpu) && $stable(post_vec)));

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && !post_ready) |-> !cmd_ready);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_halt_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(halted & ~$past(halted))) |-> ((halted & ~$past(halted) & ~halt_req) == '0));

  assert_post_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> ({1'b0, post_cpu} < LIMIT));

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_req) && $onehot0(halt_req) && $onehot0(resume_req)
    && ($countones({|rst_req, |halt_req, |resume_req}) <= 1));

  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|{rst_req, halt_req, resume_req}) |-> $past(cmd_valid && cmd_ready));
endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .post_valid(post_valid), .post_ready(post_ready),
  .post_cpu(post_cpu), .post_vec(post_vec),
  .rst_req(rst_req), .halt_req(halt_req), .resume_req(resume_req),
  .halted(halted), .err_sticky(err_sticky)
);

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
  localparam int N  = 6;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [17:0]   cmd_word = '0;
  logic          post_valid;
  logic          post_ready = 1'b1;
  logic [4:0]    post_cpu;
  logic [5:0]    post_vec;
  logic [N-1:0]  rst_req, halt_req, resume_req, halted;
  logic          err_sticky;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ipi_dispatch #(.NUM_CPUS(N)) i_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .post_valid(post_valid), .post_ready(post_ready),
    .post_cpu(post_cpu), .post_vec(post_vec), .rst_req(rst_req),
    .halt_req(halt_req), .resume_req(resume_req), .halted(halted),
    .err_sticky(err_sticky)
  );

  // kind column: 0 nothing, 1 post, 2 reset, 3 halt, 4 resume
  localparam logic [17:0] V_WORD [NV] = '{
    18'h00215, 18'h0053F, 18'h00601, 18'h20300, 18'h0E3C7,
    18'h20600, 18'h30300, 18'h10101, 18'h11F02, 18'h10102,
    18'h20000, 18'h20000, 18'h10001, 18'h30400, 18'h20500};
  localparam int V_KIND [NV] = '{1,1,0,3,1, 0,4,2,0,0, 3,3,2,4,3};
  localparam int V_CPU  [NV] = '{2,5,0,3,3, 0,3,1,0,0, 0,0,0,4,5};
  localparam int V_VEC  [NV] = '{21,63,0,0,7, 0,0,0,0,0, 0,0,0,0,0};
  localparam logic [N-1:0] V_HALT [NV] = '{
    6'h00, 6'h00, 6'h00, 6'h08, 6'h08, 6'h08, 6'h00, 6'h00,
    6'h00, 6'h00, 6'h01, 6'h01, 6'h00, 6'h00, 6'h20};
  localparam logic V_ERR [NV] = '{0,0,0,0,0, 0,0,0,0,1, 1,1,1,1,1};
  localparam string V_TAG [NV] = '{"R2","R2","R8","R6","R1","R8","R7","R4",
                                   "R8","R5","R6","R6","R4","R7","R6"};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [17:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(post_valid == 0 && rst_req == 0 && halt_req == 0 && resume_req == 0,
        "R9", "outputs", {post_valid, rst_req, halt_req, resume_req}, 0);
    chk(halted == 0 && err_sticky == 0, "R9", "status", {err_sticky, halted}, 0);
    chk(cmd_ready == 1, "R9", "cmd_ready", cmd_ready, 1);

    for (int k = 0; k < NV; k++) begin
      logic [N-1:0] one;
      one = (V_KIND[k] != 0) ? N'(1) << V_CPU[k] : '0;
      send(V_WORD[k]);
      chk(post_valid == (V_KIND[k] == 1), V_TAG[k], "post_valid", post_valid, V_KIND[k] == 1);
      if (V_KIND[k] == 1)
        chk(post_cpu == 5'(V_CPU[k]) && post_vec == 6'(V_VEC[k]), V_TAG[k], "post payload",
            {post_cpu, post_vec}, {5'(V_CPU[k]), 6'(V_VEC[k])});
      chk(rst_req == (V_KIND[k] == 2 ? one : '0), V_TAG[k], "rst_req", rst_req,
          V_KIND[k] == 2 ? one : '0);
      chk(halt_req == (V_KIND[k] == 3 ? one : '0), V_TAG[k], "halt_req", halt_req,
          V_KIND[k] == 3 ? one : '0);
      chk(resume_req == (V_KIND[k] == 4 ? one : '0), V_TAG[k], "resume_req", resume_req,
          V_KIND[k] == 4 ? one : '0);
      chk(halted == V_HALT[k], V_TAG[k], "halted", halted, V_HALT[k]);
      chk(err_sticky == V_ERR[k], V_TAG[k], "err_sticky", err_sticky, V_ERR[k]);
      @(negedge clk);
      chk(rst_req == 0 && halt_req == 0 && resume_req == 0, "R10", "pulse width",
          {rst_req, halt_req, resume_req}, 0);
    end

    // R3 back-pressure on the post output
    @(negedge clk);
    post_ready = 1'b0;
    send(18'h00409);
    chk(post_valid && post_cpu == 4 && post_vec == 9, "R3", "post loaded",
        {post_valid, post_cpu, post_vec}, {1'b1, 5'd4, 6'd9});
    chk(cmd_ready == 0, "R3", "cmd_ready stalled", cmd_ready, 0);
    cmd_word  = 18'h00103;
    cmd_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(post_valid && post_cpu == 4 && post_vec == 9, "R3", "post held",
        {post_valid, post_cpu, post_vec}, {1'b1, 5'd4, 6'd9});
    post_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(post_valid && post_cpu == 1 && post_vec == 3, "R3", "next post",
        {post_valid, post_cpu, post_vec}, {1'b1, 5'd1, 6'd3});
    @(negedge clk);
    chk(post_valid == 0, "R3", "post drained", post_valid, 0);
    chk(halted == 6'h20 && err_sticky, "R5", "state kept", {err_sticky, halted}, 7'h60);

    // R9 reset clears sticky and halted state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(halted == 0 && err_sticky == 0 && post_valid == 0, "R9", "after reset",
        {post_valid, err_sticky, halted}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule